// File: doc/BRIEF.md
# Serial Interface Status Register

This block assembles the readable 8-bit status byte of a programmable serial communications interface. It takes per-character events from the receiver (a character loaded into the receive buffer, with side flags for a parity mismatch and a missing stop bit), a strobe for each processor read of that buffer, and an error-clear strobe raised when a command write carries bit 4 high. It also takes the live transmitter, sync/break and modem-line levels. Parity, overrun and framing errors are held in sticky flags until an explicit clear arrives.

The byte is registered, so a processor read sees a value that holds through its bus cycle, and reading it changes nothing. Level inputs appear in the byte one clock after they are sampled. Events appear two clocks after their pulse: one edge updates the flag and the next edge updates the byte. The block also drives the external transmitter-ready pin. That pin, unlike status bit 0, is qualified by clear-to-send and by the transmit-enable command bit.

Top module: `ser_status_reg`

## Requirements
- R1: While rst_ni is low, status_o is 0x00 and every error flag and the receiver-ready state are cleared.
- R2: status_o bit 0 is tx_ready_i, bit 2 is tx_empty_i, bit 6 is syn_brk_i and bit 7 is the inverse of dsr_ni, each as sampled at the previous clock edge.
- R3: txrdy_o is high exactly when tx_ready_i is high, cts_ni is low and tx_en_i is high, with no clock delay. Status bit 0 ignores cts_ni and tx_en_i.
- R4: Status bit 1 (receiver ready) is set by rx_load_i and cleared by rbr_read_i. If both occur in the same cycle, the load wins.
- R5: Status bit 3 (parity error) is set by rx_load_i with rx_par_err_i high while parity_en_i is high. It is never set while parity_en_i is low.
- R6: Status bit 4 (overrun) is set by rx_load_i when receiver ready was already set before that load.
- R7: Status bit 5 (framing error) is set by rx_load_i with rx_frm_err_i high.
- R8: Bits 3 to 5 stay set after their event until a clear source acts. A receive-buffer read does not clear them.
- R9: cmd_err_rst_i (command write with bit 4 high) clears bits 3 to 5. A new error set in the same cycle wins over this clear.
- R10: int_reset_i clears bits 1 and 3 to 5 and wins over any set in the same cycle.
- R11: Event effects appear in status_o two clock edges after the event cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low full reset |
| int_reset_i | input | 1 | Internal reset command strobe |
| cmd_err_rst_i | input | 1 | Command write with error-reset bit 4 set |
| rx_load_i | input | 1 | Character loaded into receive buffer |
| rx_par_err_i | input | 1 | Parity mismatch on the loaded character |
| rx_frm_err_i | input | 1 | Missing stop bit on the loaded character |
| parity_en_i | input | 1 | Parity checking enabled |
| rbr_read_i | input | 1 | Processor read of receive buffer |
| tx_ready_i | input | 1 | Transmitter can take a byte |
| tx_empty_i | input | 1 | Transmitter fully drained |
| syn_brk_i | input | 1 | Sync/break detect level |
| dsr_ni | input | 1 | Data set ready, active low |
| cts_ni | input | 1 | Clear to send, active low |
| tx_en_i | input | 1 | Transmit-enable command bit |
| status_o | output | 8 | Registered status byte |
| txrdy_o | output | 1 | Gated transmitter-ready pin |

## Verification
The bench drives every combination of load, both error flags, parity enable, buffer read and error clear, twice in a row from varied prior state. This catches a design that clears the flags on a buffer read, one that lets the error clear override a simultaneous new error, or one that evaluates overrun after the load instead of before it. All 64 level combinations are swept to expose a status bit 0 that wrongly follows the pin gating, or a bit 7 that is not inverted. Internal resets are mixed in with set events; a design that lets a set win there would leave a flag standing.

// File: rtl/ser_status_pkg.sv
package ser_status_pkg;
  localparam int STAT_W  = 8;
  localparam int NUM_ERR = 3;
  // status byte bit positions, decoded by the processor side
  localparam int BIT_TXRDY  = 0;
  localparam int BIT_RXRDY  = 1;
  localparam int BIT_TXEMP  = 2;
  localparam int BIT_ERR0   = 3;
  localparam int BIT_SYNBRK = 6;
  localparam int BIT_DSR    = 7;
  typedef enum int {ERR_PAR = 0, ERR_OVR = 1, ERR_FRM = 2} err_idx_e;
endpackage

// File: rtl/ser_err_flag.sv
module ser_err_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic int_rst_i,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flag_q <= 1'b0;
    else if (int_rst_i) flag_q <= 1'b0;
    else if (set_i)     flag_q <= 1'b1;  // set beats error-clear command
    else if (clr_i)     flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !int_rst_i) |=> flag_o);
  assert_int_reset_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_rst_i |=> !flag_o);
  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i && !int_rst_i) |=> $stable(flag_o));
endmodule

// File: rtl/ser_rx_ready.sv
module ser_rx_ready (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic int_rst_i,
  input  logic load_i,
  input  logic read_i,
  output logic rdy_o,
  output logic ovr_set_o
);
  logic rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdy_q <= 1'b0;
    else if (int_rst_i) rdy_q <= 1'b0;
    else if (load_i)    rdy_q <= 1'b1;
    else if (read_i)    rdy_q <= 1'b0;
  end

  // overrun judged on the pre-load state
  assign ovr_set_o = load_i & rdy_q;
  assign rdy_o     = rdy_q;

  assert_load_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !int_rst_i) |=> rdy_o);
  assert_read_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_i && !load_i) |=> !rdy_o);
endmodule

// File: rtl/ser_status_pack.sv
module ser_status_pack #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] stat_d_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d_i;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/ser_status_reg.sv
module ser_status_reg
  import ser_status_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              int_reset_i,
  input  logic              cmd_err_rst_i,
  input  logic              rx_load_i,
  input  logic              rx_par_err_i,
  input  logic              rx_frm_err_i,
  input  logic              parity_en_i,
  input  logic              rbr_read_i,
  input  logic              tx_ready_i,
  input  logic              tx_empty_i,
  input  logic              syn_brk_i,
  input  logic              dsr_ni,
  input  logic              cts_ni,
  input  logic              tx_en_i,
  output logic [STAT_W-1:0] status_o,
  output logic              txrdy_o
);
  logic               rx_rdy;
  logic               ovr_set;
  logic [NUM_ERR-1:0] err_set;
  logic [NUM_ERR-1:0] err_q;
  logic [STAT_W-1:0]  stat_d;

  ser_rx_ready u_rx_ready (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .int_rst_i (int_reset_i),
    .load_i    (rx_load_i),
    .read_i    (rbr_read_i),
    .rdy_o     (rx_rdy),
    .ovr_set_o (ovr_set)
  );

  assign err_set[ERR_PAR] = rx_load_i & rx_par_err_i & parity_en_i;
  assign err_set[ERR_OVR] = ovr_set;
  assign err_set[ERR_FRM] = rx_load_i & rx_frm_err_i;

  for (genvar g = 0; g < NUM_ERR; g++) begin : g_err
    ser_err_flag u_flag (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .int_rst_i (int_reset_i),
      .set_i     (err_set[g]),
      .clr_i     (cmd_err_rst_i),
      .flag_o    (err_q[g])
    );
  end

  always_comb begin
    stat_d                                 = '0;
    stat_d[BIT_TXRDY]                      = tx_ready_i;
    stat_d[BIT_RXRDY]                      = rx_rdy;
    stat_d[BIT_TXEMP]                      = tx_empty_i;
    stat_d[BIT_ERR0 +: NUM_ERR]            = err_q;
    stat_d[BIT_SYNBRK]                     = syn_brk_i;
    stat_d[BIT_DSR]                        = ~dsr_ni;
  end

  ser_status_pack #(.W(STAT_W)) u_pack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stat_d_i (stat_d),
    .stat_o   (status_o)
  );

  assign txrdy_o = tx_ready_i & ~cts_ni & tx_en_i;

  assert_no_par_when_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!parity_en_i && !err_q[ERR_PAR]) |=> !err_q[ERR_PAR]);
  assert_dsr_inverted_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (status_o[BIT_DSR] == !$past(dsr_ni)));
  assert_txrdy_bit_ungated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (status_o[BIT_TXRDY] == $past(tx_ready_i)));
  assert_txrdy_pin_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txrdy_o |-> (!cts_ni && tx_en_i));
endmodule

// File: tb/tb_ser_status_reg.sv
module tb_ser_status_reg;
  logic clk = 1'b0, rst_n = 1'b0;
  logic int_rst = 0, clr = 0, load = 0, perr = 0, ferr = 0, pen = 0, rd = 0;
  logic txr = 0, txe = 0, syn = 0, dsr_n = 1, cts_n = 1, ten = 0;
  logic [7:0] status;
  logic txrdy;
  int checks = 0, fails = 0;
  logic m_rx = 0, m_pe = 0, m_oe = 0, m_fe = 0;

  always #10 clk = ~clk;

  ser_status_reg dut (
    .clk_i(clk), .rst_ni(rst_n), .int_reset_i(int_rst), .cmd_err_rst_i(clr),
    .rx_load_i(load), .rx_par_err_i(perr), .rx_frm_err_i(ferr), .parity_en_i(pen),
    .rbr_read_i(rd), .tx_ready_i(txr), .tx_empty_i(txe), .syn_brk_i(syn),
    .dsr_ni(dsr_n), .cts_ni(cts_n), .tx_en_i(ten), .status_o(status), .txrdy_o(txrdy)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_stat();
    return {~dsr_n, syn, m_fe, m_oe, m_pe, txe, m_rx, txr};
  endfunction

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", status, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3: level sweep
    for (int i = 0; i < 64; i++) begin
      {txr, txe, syn, dsr_n, cts_n, ten} = 6'(i);
      #1 chk("R3 txrdy pin", {7'b0, txrdy}, {7'b0, txr & ~cts_n & ten});
      @(negedge clk);
      chk("R2 R3 level bits", status, exp_stat());
    end

    // R4-R11: event sweep
    for (int rep = 0; rep < 2; rep++) begin
      for (int c = 0; c < 64; c++) begin
        logic set_pe, set_oe, set_fe;
        {load, perr, ferr, pen, rd, clr} = 6'(c ^ (rep * 21));
        set_pe = load & perr & pen;
        set_oe = load & m_rx;
        set_fe = load & ferr;
        m_pe = set_pe | (m_pe & ~clr);
        m_oe = set_oe | (m_oe & ~clr);
        m_fe = set_fe | (m_fe & ~clr);
        m_rx = load ? 1'b1 : (rd ? 1'b0 : m_rx);
        @(negedge clk);
        {load, perr, ferr, rd, clr} = '0;
        @(negedge clk);
        chk("R4 R5 R6 R7 R8 R9 R11 event", status, exp_stat());
        if (c % 16 == 15) begin
          int_rst = 1'b1; load = 1'b1; perr = 1'b1; ferr = 1'b1; pen = 1'b1;
          m_rx = 0; m_pe = 0; m_oe = 0; m_fe = 0;
          @(negedge clk);
          {int_rst, load, perr, ferr} = '0;
          @(negedge clk);
          chk("R10 internal reset", status, exp_stat());
        end
      end
    end

    // R5: parity disabled never flags
    pen = 0; load = 1; perr = 1;
    m_oe = m_oe | m_rx; m_rx = 1;
    @(negedge clk);
    {load, perr} = '0;
    @(negedge clk);
    chk("R5 parity off", status, exp_stat());

    // R1: full reset mid-run
    rst_n = 0;
    #1 chk("R1 async reset", status, 8'h00);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule